// File: doc/BRIEF.md
# Dark-Column Black Level Restorer

This block sits on the digitized pixel stream of one sensor output channel. A line-start flag marks the first sample of each line, and a frame-start flag, given with it, marks the first line of a frame. From its position counted after the line-start flag, each sample is sorted into one of three kinds: a padding sample with no image content, a light-shielded reference sample, or an image pixel.

The shielded samples of a line are averaged by multiplying their sum with a fixed-point reciprocal. That average is folded into a running black estimate through a first-order recursive filter whose strength is set by a shift input. The estimate is then subtracted from every image pixel of the same line. Only corrected image pixels leave the block, each with a valid strobe, line and frame markers and a flag for the shielded rows at the top of the frame. A length monitor reports lines that do not carry the expected number of samples.

Top module: `blacklevel_restorer`

## Requirements
- R1: While reset is low and in the first cycle after it, every output is 0, and the black estimate restarts at 0.
- R2: The positions 0 to N_DUMMY-1 (padding) and N_DUMMY to N_DUMMY+N_DARK-1 (shielded) of a line, counted from 0 at the line-start sample, never raise o_valid.
- R3: Each sample at position N_DUMMY+N_DARK up to N_DUMMY+N_DARK+N_ACTIVE-1 produces exactly one o_valid pulse, one cycle later and in input order.
- R4: At the last shielded sample the line mean is formed as floor(sum × K / 65536), with K = floor((65536 + N_DARK/2) / N_DARK), saturated to the largest data value.
- R5: At that sample the estimate B is updated to B + ((mean − B) >>> i_shift), using an arithmetic shift, and the new B applies to the image pixels of the same line. With i_shift = 0, B takes the mean directly.
- R6: o_data equals the input pixel minus B, or 0 when the pixel is less than B.
- R7: o_sol is high with the first image pixel of each line. o_sof is high with that pixel only on the line that began with i_sof.
- R8: o_dark_line is high on the outputs of the first N_DARK_LINES lines after a frame start. Before any frame start, no line counts as such a line.
- R9: o_len_err pulses for one cycle, the cycle after a line-start sample, when the previous line did not have exactly N_DUMMY+N_DARK+N_ACTIVE samples. It never pulses on the first line after reset.
- R10: Samples that arrive before the first line-start after reset, and samples past the end of a line, produce no output and do not change B.
- R11: Cycles with i_valid low do not advance the position and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i_valid | input | 1 | Sample strobe |
| i_sol | input | 1 | Marks the first sample of a line |
| i_sof | input | 1 | With i_sol, marks the first line of a frame |
| i_data | input | DATA_W | Sample value |
| i_shift | input | SH_W | Filter shift, sampled at the last shielded sample |
| o_valid | output | 1 | Corrected pixel strobe |
| o_data | output | DATA_W | Corrected pixel |
| o_sol | output | 1 | First image pixel of a line |
| o_sof | output | 1 | First image pixel of a frame |
| o_dark_line | output | 1 | Pixel belongs to a shielded row |
| o_len_err | output | 1 | Previous line had the wrong length |

## Verification
If the position counter is off by even one sample, the o_valid pulses move against the stimulus on the very next line, and a shielded sample leaks into the output. A wrong accumulator or filter state shows up on the first image pixel after the next last-shielded sample, as a wrong o_data or as a clamp to zero that should not happen. The bench models the position, mean and filter rules itself and compares every output in every cycle. Its patterns include idle gaps, filter shifts from 0 to 3, pixels at full scale and pixels below the estimate, lines that are too short and too long, and a reset in the middle of the run.

// File: rtl/brl_pkg.sv
// Package: shared constants and helpers for the black level restorer.
// Assumes: reciprocal precision of 16 fractional bits suffices for N_DARK <= 256.
package brl_pkg;
    localparam int RECIP_FRAC = 16;

    // Rounded fixed-point reciprocal of n with RECIP_FRAC fraction bits.
    function automatic int recip(input int n);
        return ((1 << RECIP_FRAC) + n / 2) / n;
    endfunction
endpackage

// File: rtl/brl_pos_tracker.sv
// Module: tracks the sample position inside a line and the line index inside a frame,
// and checks line length at every line start.
// Assumes: i_sof is only meaningful together with i_sol; position and line saturate.
module brl_pos_tracker #(
    parameter int LINE_LEN = 684,
    parameter int CW       = 11,
    parameter int LW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_valid,
    input  logic          i_sol,
    input  logic          i_sof,
    output logic          o_live,
    output logic [CW-1:0] o_pos,
    output logic [LW-1:0] o_line,
    output logic          o_len_err
);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [LW-1:0] LMAX = '1;

    logic [CW-1:0] cnt_q;
    logic [LW-1:0] line_q;
    logic          seen_q;
    logic          start;

    // Position and line index of the sample presented this cycle.
    always_comb begin
        start  = i_valid && i_sol;
        o_live = seen_q || start;
        o_pos  = start ? '0 : cnt_q;
        if (start && i_sof)
            o_line = '0;
        else if (start)
            o_line = (line_q == LMAX) ? LMAX : line_q + LW'(1);
        else
            o_line = line_q;
    end

    // Advance counters on accepted samples and flag bad line lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= CMAX;
            line_q    <= LMAX;
            seen_q    <= 1'b0;
            o_len_err <= 1'b0;
        end else begin
            o_len_err <= start && seen_q && (cnt_q != CW'(LINE_LEN));
            if (i_valid && o_live) begin
                cnt_q  <= (o_pos == CMAX) ? CMAX : o_pos + CW'(1);
                line_q <= o_line;
            end
            if (start)
                seen_q <= 1'b1;
        end
    end

    p_err_needs_sol_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_len_err |-> $past(i_valid && i_sol));
endmodule

// File: rtl/brl_black_est.sv
// Module: sums the shielded samples of a line, forms their mean by reciprocal multiply,
// and folds it into a recursively filtered black estimate.
// Assumes: i_first and i_last are only high together with i_dark.
module brl_black_est #(
    parameter int DATA_W = 12,
    parameter int N_DARK = 22,
    parameter int SH_W   = 3,
    parameter int SUM_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_dark,
    input  logic              i_first,
    input  logic              i_last,
    input  logic [DATA_W-1:0] i_data,
    input  logic [SH_W-1:0]   i_shift,
    output logic [DATA_W-1:0] o_black
);
    import brl_pkg::*;
    localparam int RECIP  = recip(N_DARK);
    localparam int PROD_W = SUM_W + RECIP_FRAC + 1;
    localparam int MAXV   = (1 << DATA_W) - 1;

    logic [SUM_W-1:0]         sum_q, sum_next;
    logic [PROD_W-1:0]        prod, mean_w;
    logic [DATA_W-1:0]        mean;
    logic signed [DATA_W+1:0] diff, step, nxt;

    // Running sum, line mean and filtered estimate for this sample.
    always_comb begin
        sum_next = i_first ? SUM_W'(i_data) : sum_q + SUM_W'(i_data);
        prod     = PROD_W'(sum_next) * PROD_W'(RECIP);
        mean_w   = prod >> RECIP_FRAC;
        mean     = (mean_w > PROD_W'(MAXV)) ? DATA_W'(MAXV) : mean_w[DATA_W-1:0];
        diff     = $signed({2'b00, mean}) - $signed({2'b00, o_black});
        step     = diff >>> i_shift;
        nxt      = $signed({2'b00, o_black}) + step;
    end

    // Accumulate shielded samples; update the estimate at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            o_black <= '0;
        end else if (i_dark) begin
            sum_q <= sum_next;
            if (i_last)
                o_black <= nxt[DATA_W-1:0];
        end
    end

    p_est_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_dark && i_last) |-> (nxt[DATA_W+1:DATA_W] == 2'b00));

    p_est_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_dark && i_last) |=>
            (o_black <= (($past(o_black) > $past(mean)) ? $past(o_black) : $past(mean))) &&
            (o_black >= (($past(o_black) < $past(mean)) ? $past(o_black) : $past(mean))));
endmodule

// File: rtl/brl_pix_out.sv
// Module: subtracts the black estimate from image pixels with a floor at zero and
// registers the output strobe and markers.
// Assumes: i_black is already updated for the current line.
module brl_pix_out #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_act,
    input  logic              i_first,
    input  logic              i_frame0,
    input  logic              i_dl,
    input  logic [DATA_W-1:0] i_data,
    input  logic [DATA_W-1:0] i_black,
    output logic              o_valid,
    output logic [DATA_W-1:0] o_data,
    output logic              o_sol,
    output logic              o_sof,
    output logic              o_dark_line
);
    logic [DATA_W:0] diff;

    // Widened difference; top bit set means the pixel is below black.
    always_comb diff = {1'b0, i_data} - {1'b0, i_black};

    // Register corrected pixel and markers for image pixels only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid     <= 1'b0;
            o_data      <= '0;
            o_sol       <= 1'b0;
            o_sof       <= 1'b0;
            o_dark_line <= 1'b0;
        end else begin
            o_valid     <= i_act;
            o_data      <= !i_act ? '0 : (diff[DATA_W] ? '0 : diff[DATA_W-1:0]);
            o_sol       <= i_act && i_first;
            o_sof       <= i_act && i_first && i_frame0;
            o_dark_line <= i_act && i_dl;
        end
    end

    p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (o_data <= $past(i_data)));

    p_sof_with_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        o_sof |-> (o_sol && o_valid));
endmodule

// File: rtl/blacklevel_restorer.sv
// Module: top of the black level restorer. Decodes sample positions into padding,
// shielded and image ranges, and ties tracker, estimator and output stage together.
// Assumes: samples arrive padding first, then shielded, then image, after each line start.
module blacklevel_restorer #(
    parameter int DATA_W       = 12,
    parameter int N_DUMMY      = 4,
    parameter int N_DARK       = 22,
    parameter int N_ACTIVE     = 658,
    parameter int N_LINES      = 500,
    parameter int N_DARK_LINES = 4,
    parameter int SH_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic              i_sol,
    input  logic              i_sof,
    input  logic [DATA_W-1:0] i_data,
    input  logic [SH_W-1:0]   i_shift,
    output logic              o_valid,
    output logic [DATA_W-1:0] o_data,
    output logic              o_sol,
    output logic              o_sof,
    output logic              o_dark_line,
    output logic              o_len_err
);
    localparam int LINE_LEN = N_DUMMY + N_DARK + N_ACTIVE;
    localparam int CW       = $clog2(LINE_LEN + 1) + 1;
    localparam int LW       = $clog2(N_LINES) + 1;
    localparam int SUM_W    = DATA_W + $clog2(N_DARK + 1);
    localparam int DARK_LO  = N_DUMMY;
    localparam int DARK_HI  = N_DUMMY + N_DARK - 1;
    localparam int ACT_LO   = N_DUMMY + N_DARK;

    logic              live;
    logic [CW-1:0]     pos;
    logic [LW-1:0]     line;
    logic              samp, is_dark, is_act;
    logic [DATA_W-1:0] black;

    brl_pos_tracker #(.LINE_LEN(LINE_LEN), .CW(CW), .LW(LW)) u_trk (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sol(i_sol), .i_sof(i_sof),
        .o_live(live), .o_pos(pos), .o_line(line), .o_len_err(o_len_err)
    );

    // Classify the current sample by its position in the line.
    always_comb begin
        samp    = i_valid && live;
        is_dark = samp && (pos >= CW'(DARK_LO)) && (pos <= CW'(DARK_HI));
        is_act  = samp && (pos >= CW'(ACT_LO)) && (pos < CW'(LINE_LEN));
    end

    brl_black_est #(.DATA_W(DATA_W), .N_DARK(N_DARK), .SH_W(SH_W), .SUM_W(SUM_W)) u_est (
        .clk(clk), .rst_n(rst_n), .i_dark(is_dark),
        .i_first(pos == CW'(DARK_LO)), .i_last(pos == CW'(DARK_HI)),
        .i_data(i_data), .i_shift(i_shift), .o_black(black)
    );

    brl_pix_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .i_act(is_act), .i_first(pos == CW'(ACT_LO)),
        .i_frame0(line == '0), .i_dl(line < LW'(N_DARK_LINES)),
        .i_data(i_data), .i_black(black),
        .o_valid(o_valid), .o_data(o_data), .o_sol(o_sol), .o_sof(o_sof),
        .o_dark_line(o_dark_line)
    );

    p_out_needs_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> $past(i_valid));
endmodule

// File: tb/tb_blacklevel_restorer.sv
`timescale 1ns/1ps
module tb_blacklevel_restorer;
    localparam int DW = 12, ND = 4, NK = 22, NA = 6, NL = 8, NDL = 2, SW = 3;
    localparam int LEN = ND + NK + NA, ACT_LO = ND + NK, CMAX = 127;
    localparam int K = (65536 + NK / 2) / NK;

    logic clk = 0, rst_n = 0, i_valid = 0, i_sol = 0, i_sof = 0;
    logic [DW-1:0] i_data = '0;
    logic [SW-1:0] i_shift = '0;
    logic o_valid, o_sol, o_sof, o_dark_line, o_len_err;
    logic [DW-1:0] o_data;

    blacklevel_restorer #(.DATA_W(DW), .N_DUMMY(ND), .N_DARK(NK), .N_ACTIVE(NA),
        .N_LINES(NL), .N_DARK_LINES(NDL), .SH_W(SW)) dut (.*);

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    // reference model state
    int m_seen = 0, m_cnt = CMAX, m_pos = 0, m_line = 1000, m_acc = 0, m_f = 0, m_sh = 0;
    int p_v = 0, p_d = 0, p_sol = 0, p_sof = 0, p_dl = 0, p_err = 0;
    string tv = "R1", td = "R4";

    // rows: sof, dark base, image base, image step, shift, gaps
    localparam int NROW = 8;
    localparam int TBL [NROW][6] = '{
        '{1, 100,  500,  40, 0, 0},
        '{0, 200,  150,  30, 1, 1},
        '{0,  60,   20,  25, 2, 0},
        '{0, 4000, 4095,  0, 0, 1},
        '{0,   0, 3000, 100, 3, 0},
        '{1, 300,  250,  20, 0, 1},
        '{0, 310,  900, 500, 1, 0},
        '{0,  50,    0,   1, 0, 0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(o_valid == p_v[0], tv, o_valid, p_v);
        if (p_v != 0) begin
            chk(o_data == p_d[DW-1:0], td, o_data, p_d);
            chk(o_sol == p_sol[0], "R7", o_sol, p_sol);
            chk(o_sof == p_sof[0], "R7", o_sof, p_sof);
            chk(o_dark_line == p_dl[0], "R8", o_dark_line, p_dl);
        end
        chk(o_len_err == p_err[0], "R9", o_len_err, p_err);
    endtask

    task automatic drive(input bit v, input bit s, input bit f, input int d, input int sh);
        int m;
        @(negedge clk);
        check_outputs();
        i_valid = v; i_sol = s; i_sof = f; i_data = d[DW-1:0]; i_shift = sh[SW-1:0];
        p_v = 0; p_d = 0; p_sol = 0; p_sof = 0; p_dl = 0; p_err = 0; tv = "R11";
        if (v) begin
            if (s) begin
                if (m_seen != 0 && m_cnt != LEN) p_err = 1;
                m_seen = 1; m_pos = 0; m_line = f ? 0 : m_line + 1;
            end else m_pos = m_cnt;
            if (m_seen == 0) tv = "R10";
            else begin
                m_cnt = (m_pos + 1 > CMAX) ? CMAX : m_pos + 1;
                tv = (m_pos < ACT_LO) ? "R2" : (m_pos >= LEN) ? "R10" : "R3";
                if (m_pos >= ND && m_pos < ACT_LO) begin
                    m_acc = (m_pos == ND) ? d : m_acc + d;
                    if (m_pos == ACT_LO - 1) begin
                        m = (m_acc * K) >> 16;
                        if (m > 4095) m = 4095;
                        m_f = m_f + ((m - m_f) >>> sh);
                        m_sh = sh;
                    end
                end
                if (m_pos >= ACT_LO && m_pos < LEN) begin
                    p_v = 1;
                    p_d = (d > m_f) ? d - m_f : 0;
                    p_sol = (m_pos == ACT_LO);
                    p_sof = p_sol && m_line == 0;
                    p_dl = m_line < NDL;
                    td = (p_d == 0) ? "R6" : (m_sh != 0) ? "R5" : "R4";
                end
            end
        end
    endtask

    task automatic send_line(input bit sof, input int db, input int ab, input int st,
                             input int sh, input bit gap, input int n);
        for (int k = 0; k < n; k++) begin
            int val;
            if (k < ND) val = 999;
            else if (k < ACT_LO) val = db + (k % 4) * 3;
            else val = ab + (k - ACT_LO) * st;
            if (val > 4095) val = 4095;
            drive(1, k == 0, sof && k == 0, val, sh);
            if (gap && (k % 2 == 1)) drive(0, 0, 0, 1234, sh);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_outputs();
        rst_n = 0; i_valid = 0; i_sol = 0; i_sof = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk({o_valid, o_sol, o_sof, o_dark_line, o_len_err} == 5'b0 && o_data == 0,
                "R1", o_valid, 0);
        end
        rst_n = 1;
        m_seen = 0; m_cnt = CMAX; m_line = 1000; m_f = 0; m_acc = 0;
        p_v = 0; p_d = 0; p_sol = 0; p_sof = 0; p_dl = 0; p_err = 0; tv = "R1";
    endtask

    initial begin
        do_reset();
        // R10: samples before any line start are ignored
        for (int k = 0; k < 5; k++) drive(1, 0, 0, 4000, 0);
        // table walk: R2..R8, R11
        for (int r = 0; r < NROW; r++)
            send_line(TBL[r][0] != 0, TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4],
                      TBL[r][5] != 0, LEN);
        // R9: short line, then long line (extra samples ignored, R10), then good line
        send_line(0, 80, 400, 10, 0, 0, LEN - 4);
        send_line(0, 90, 400, 10, 0, 0, LEN + 3);
        send_line(0, 90, 400, 10, 0, 0, LEN);
        send_line(1, 70, 100, 10, 0, 0, LEN);
        // R1/R9: reset mid-run, a short line first gives no error
        do_reset();
        send_line(0, 40, 60, 5, 0, 0, LEN - 2);
        send_line(1, 40, 60, 5, 0, 0, LEN);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule